// File: doc/BRIEF.md
# GF(2) Feedback Descrambler

This block undoes a three-tap feed-forward scrambler on a serial bit stream. Each accepted input bit passes through a three-stage delay line. The bit leaving the far end of that line is combined by exclusive-or with earlier output bits, and each earlier output bit is first gated by one bit of a programmable coefficient vector. The result is the next output bit, and it is also shifted into an output history register so that it feeds back into later bits.

In a link, the sending side applies s_n = m_n ^ a1·m_{n-1} ^ a2·m_{n-2} ^ a3·m_{n-3}. The receiving side loads the same three coefficients into this block and resets it in the same cycle as the sender. The block then reproduces the sender's message exactly three accepted bits later. All arithmetic is modulo 2, so subtracting the feedback terms is the same as adding them. The stream may pause: a sample is taken only when the valid strobe is high, and the whole state stands still while it is low.

Top module: `gf2_feedback_descrambler`

## Requirements
- R1: During synchronous reset, and in the first cycle after it, `dout_o` is 0. The delay line and the output history are all cleared, so an all-zero input stream after reset gives an all-zero output for any coefficient vector.
- R2: At every rising edge with `valid_i` high, `dout_o` becomes y_n = x_{n-3} ^ (b1 & y_{n-1}) ^ (b2 & y_{n-2}) ^ (b3 & y_{n-3}). Here x is the accepted input stream and y is the output stream, and both are 0 before reset is released. `coef_i[0]` is b1, `coef_i[1]` is b2 and `coef_i[2]` is b3.
- R3: If the input stream comes from a scrambler with a0 = 1 and a_i = b_i, and that scrambler was reset together with this block, then the output after the n-th accepted bit equals the scrambler's message bit n-3.
- R4: While `valid_i` is low, `dout_o` and all internal state hold. The values on `din_i` and `coef_i` have no effect, and the next accepted bit continues the recursion as if the pause had not happened.
- R5: With `coef_i` = 000, the output is the accepted input stream delayed by exactly three accepted bits.
- R6: `coef_i` is sampled on every accepted bit. A change in the coefficient vector applies from the first edge at which it is presented with `valid_i` high.
- R7: Reset takes priority over `valid_i` in the same cycle. A bit presented with `valid_i` high during reset is discarded, and no trace of it appears in later output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | High when `din_i` carries a bit to accept |
| din_i | input | 1 | Scrambled serial input bit |
| coef_i | input | ORDER | Feedback coefficients; bit i gates the output from i+1 accepted bits ago |
| dout_o | output | 1 | Registered descrambled output bit |

## Verification
Two events can land on the same edge. The first pair is a reset and an accepted bit. The bench loads the state with ones, then raises reset and valid together with a 1 on the input. It then feeds zeros with all feedback taps enabled, and any surviving 1 would circulate and show at the output. The second pair is a coefficient change and an accepted bit. Coefficients are drawn afresh on every accepted cycle, and each output is compared with a model that applies the recursion using the coefficients presented at that edge.

// File: rtl/descr_pkg.sv
`timescale 1ns/1ps
package descr_pkg;
  // Default recursion order: three delay stages and three feedback taps.
  localparam int unsigned DEFAULT_ORDER = 3;
endpackage

// File: rtl/descr_delay_line.sv
`timescale 1ns/1ps
module descr_delay_line #(
  parameter int unsigned DEPTH = descr_pkg::DEFAULT_ORDER
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic din,
  output logic tap
);
  logic [DEPTH-1:0] line_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)      line_q <= '0;
        else if (adv) line_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)      line_q <= '0;
        else if (adv) line_q <= {line_q[DEPTH-2:0], din};
      end
    end
  endgenerate

  // Oldest accepted bit leaves the far end of the line.
  assign tap = line_q[DEPTH-1];

  AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(line_q)); // R4
endmodule

// File: rtl/descr_fb_sum.sv
`timescale 1ns/1ps
module descr_fb_sum #(
  parameter int unsigned ORDER = descr_pkg::DEFAULT_ORDER
) (
  input  logic             tap,
  input  logic [ORDER-1:0] coef,
  input  logic [ORDER-1:0] hist,
  output logic             y_next
);
  logic [ORDER-1:0] gated;

  generate
    for (genvar i = 0; i < ORDER; i++) begin : g_tap
      assign gated[i] = coef[i] & hist[i];
    end
  endgenerate

  // Modulo-2 sum: subtraction of feedback terms is the same XOR.
  assign y_next = tap ^ (^gated);
endmodule

// File: rtl/descr_out_history.sv
`timescale 1ns/1ps
module descr_out_history #(
  parameter int unsigned ORDER = descr_pkg::DEFAULT_ORDER
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             y_next,
  output logic [ORDER-1:0] hist,
  output logic             dout
);
  logic [ORDER-1:0] hist_q;

  generate
    if (ORDER == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)      hist_q <= '0;
        else if (adv) hist_q <= y_next;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)      hist_q <= '0;
        else if (adv) hist_q <= {hist_q[ORDER-2:0], y_next};
      end
    end
  endgenerate

  assign hist = hist_q;
  assign dout = hist_q[0];

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hist_q == '0)); // R1

  AST_HISTORY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(hist_q)); // R4
endmodule

// File: rtl/gf2_feedback_descrambler.sv
`timescale 1ns/1ps
module gf2_feedback_descrambler #(
  parameter int unsigned ORDER = descr_pkg::DEFAULT_ORDER
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic             din_i,
  input  logic [ORDER-1:0] coef_i,
  output logic             dout_o
);
  logic             tap_w;
  logic             y_next_w;
  logic [ORDER-1:0] hist_w;

  descr_delay_line #(.DEPTH(ORDER)) u_delay (
    .clk (clk),
    .rst (rst),
    .adv (valid_i),
    .din (din_i),
    .tap (tap_w)
  );

  descr_fb_sum #(.ORDER(ORDER)) u_sum (
    .tap    (tap_w),
    .coef   (coef_i),
    .hist   (hist_w),
    .y_next (y_next_w)
  );

  descr_out_history #(.ORDER(ORDER)) u_hist (
    .clk    (clk),
    .rst    (rst),
    .adv    (valid_i),
    .y_next (y_next_w),
    .hist   (hist_w),
    .dout   (dout_o)
  );

  AST_RECURSION_STEP: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> dout_o == ($past(tap_w) ^ (^($past(coef_i) & $past(hist_w))))); // R2

  AST_PLAIN_DELAY: assert property (@(posedge clk) disable iff (rst)
    (valid_i && coef_i == '0) |=> dout_o == $past(tap_w)); // R5

  AST_IDLE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(dout_o)); // R4
endmodule

// File: tb/test_gf2_feedback_descrambler.sv
`timescale 1ns/1ps
module test_gf2_feedback_descrambler;
  localparam int ORDER = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             valid_i = 1'b0;
  logic             din_i = 1'b0;
  logic [ORDER-1:0] coef_i = '0;
  logic             dout_o;

  int n_checks = 0;
  int n_fails  = 0;

  // Model of the recursion: md[0] = newest input, mh[0] = newest output.
  bit [2:0] md, mh;
  // Scrambler model: sm[0] = newest message bit.
  bit [2:0] sm;
  bit       y_last;

  always #5 clk = ~clk;

  gf2_feedback_descrambler #(.ORDER(ORDER)) i_gf2_feedback_descrambler (
    .clk(clk), .rst(rst), .valid_i(valid_i), .din_i(din_i),
    .coef_i(coef_i), .dout_o(dout_o)
  );

  task automatic check(input bit got, input bit exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: dout_o=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // Drive at negedge, sample 1 ns after the rising edge, return at negedge.
  task automatic step(input bit v, input bit x, input bit [2:0] b, output bit y);
    valid_i = v; din_i = x; coef_i = b;
    @(posedge clk); #1;
    y = dout_o;
    @(negedge clk);
  endtask

  function automatic bit model_adv(input bit x, input bit [2:0] b);
    bit y;
    y  = md[2] ^ (b[0] & mh[0]) ^ (b[1] & mh[1]) ^ (b[2] & mh[2]);
    md = {md[1:0], x};
    mh = {mh[1:0], y};
    return y;
  endfunction

  task automatic do_reset();
    bit y;
    rst = 1'b1;
    step($urandom_range(0, 1), $urandom_range(0, 1), 3'($urandom), y);
    check(y, 1'b0, "R1");
    step(1'b1, 1'b1, 3'b111, y);
    rst = 1'b0;
    md = '0; mh = '0; sm = '0; y_last = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fails++;
    $display("FAIL R2: watchdog expired, dout_o=%0b expected completion", dout_o);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    bit y, x, prev;
    bit [2:0] a, b;
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R1: reset state and zero stream stays zero
    do_reset();
    check(dout_o, 1'b0, "R1");
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b0, 3'($urandom), y);
      check(y, 1'b0, "R1");
    end

    // R3 with R4 pauses: matched scrambler/descrambler pair
    for (int run = 0; run < 20; run++) begin
      a = (run == 0) ? 3'b111 : 3'($urandom);
      do_reset();
      for (int k = 0; k < 60; k++) begin
        if (($urandom % 5) != 0) begin
          x = $urandom_range(0, 1);
          din_i = x ^ (a[0] & sm[0]) ^ (a[1] & sm[1]) ^ (a[2] & sm[2]);
          prev  = sm[2];
          sm    = {sm[1:0], x};
          step(1'b1, din_i, a, y);
          check(y, prev, "R3");
          y_last = y;
        end else begin
          step(1'b0, $urandom_range(0, 1), 3'($urandom), y);
          check(y, y_last, "R4");
        end
      end
    end

    // R2/R6: arbitrary stream, coefficients changing every accepted bit
    for (int run = 0; run < 30; run++) begin
      do_reset();
      for (int k = 0; k < 40; k++) begin
        x = $urandom_range(0, 1);
        b = 3'($urandom);
        if (($urandom % 6) == 0) begin
          step(1'b0, x, b, y);
          check(y, y_last, "R4");
        end else begin
          prev = model_adv(x, b);
          step(1'b1, x, b, y);
          check(y, prev, (k % 2) ? "R6" : "R2");
          y_last = y;
        end
      end
    end

    // R5: zero coefficients give a plain three-bit delay
    do_reset();
    for (int k = 0; k < 40; k++) begin
      x = $urandom_range(0, 1);
      prev = md[2];
      void'(model_adv(x, 3'b000));
      step(1'b1, x, 3'b000, y);
      check(y, prev, "R5");
    end

    // R7: reset and valid in the same cycle; leftover ones would recirculate
    do_reset();
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 3'b111, y);
    rst = 1'b1;
    step(1'b1, 1'b1, 3'b111, y);
    check(y, 1'b0, "R7");
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b0, 3'b111, y);
      check(y, 1'b0, "R7");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule